// File: doc/BRIEF.md
# Slotted Bus Transmit Fault Injector

This block sits between a node's frame transmitter and a shared time-triggered bus. Frames arrive one byte per tick, with a start marker on the first byte and the valid strobe dropped between frames. Each frame comes with the slot number and bus cycle number it is sent in. The block forwards each byte to the bus one tick later. On command it corrupts the traffic. It can invert one chosen bit of one chosen byte. It can invert bit 0 of every byte. It can hold the whole frame back by a number of ticks. It can keep the bus idle for the whole frame.

Each of the four fault kinds has its own enable. A target is either given exactly (a slot, plus a cycle number for delay and drop) or picked pseudo-randomly, once per frame. A plain register bank drives the configuration ports. A frame whose delay would carry it past the end of its slot is suppressed, and a one-tick flag reports it. The source of the slot timing supplies the number of ticks left in the slot as an input.

Top module: `tt_fault_inj`

## Requirements
- R1: After reset, and whenever nothing is transmitted, `bus_txen_o` is 0, `bus_data_o` is 8'hFF and `dly_ovf_o` is 0.
- R2: A frame that no fault targets appears on the bus unchanged, byte for byte, with `bus_txen_o` high, one tick after each input byte.
- R3: With bit error enabled, a targeted frame has bit `tgt_bit_i` inverted in the byte whose index equals `tgt_byte_i`. The first byte has index 0. All other bytes are unchanged.
- R4: With frame error enabled, every byte of a targeted frame has bit 0 inverted.
- R5: In fixed mode, a frame is targeted only when `slot_id_i` equals `tgt_slot_i` at its start. Delay and drop also require `cycle_num_i` to equal `tgt_cycle_i`.
- R6: With delay enabled and `dly_ticks_i` = D in the range 1 to 63, a targeted frame reaches the bus D ticks later than it would otherwise. The bus stays idle in the meantime. Any enabled corruption is kept.
- R7: With drop enabled, a targeted frame produces no bus activity. The output stays at the idle level for the whole frame.
- R8: When a delay is due and D is greater than or equal to `slot_rem_i` at frame start, the frame is dropped instead. `dly_ovf_o` goes high for exactly the tick after the start byte.
- R9: With `en_rand_i` high, the slot and cycle matches are ignored. A frame is targeted when the low 3 bits of a 16-bit LFSR are all zero. The LFSR is seeded to 16'hACE1 at reset and advances at every frame start in either mode, after its value has been used. The update shifts left and feeds bit15^bit13^bit12^bit10 into bit 0.
- R10: Bit error and frame error combine on the same frame. Drop takes priority over delay, and in that case no overflow is flagged.
- R11: A delay value of 0 with delay enabled leaves frame timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Input byte valid |
| tx_sof_i | input | 1 | First byte of a frame |
| tx_data_i | input | 8 | Input byte |
| slot_id_i | input | SLOT_W | Slot the frame is sent in |
| cycle_num_i | input | CYC_W | Bus cycle number |
| slot_rem_i | input | REM_W | Ticks left in the current slot |
| en_bit_i | input | 1 | Enable single bit error |
| en_frame_i | input | 1 | Enable whole-frame error |
| en_delay_i | input | 1 | Enable frame delay |
| en_drop_i | input | 1 | Enable frame drop |
| en_rand_i | input | 1 | Pseudo-random targeting |
| tgt_slot_i | input | SLOT_W | Target slot |
| tgt_cycle_i | input | CYC_W | Target cycle for delay and drop |
| tgt_byte_i | input | BYTE_W | Byte index for bit error |
| tgt_bit_i | input | 3 | Bit position for bit error |
| dly_ticks_i | input | DLY_W | Delay in ticks |
| bus_data_o | output | 8 | Byte driven to the bus |
| bus_txen_o | output | 1 | Bus transmit enable |
| dly_ovf_o | output | 1 | Delay crossed slot end, frame dropped |

## Verification
The bench targets the edges of the slot-overflow test, with D equal to the ticks left and with D one below. An off-by-one there either lets a late frame spill into the next slot or silently drops a frame that fits. It uses the largest delay of 63 to catch an off-by-one in the ring read that would shift or garble the released frame. It sends frames into a matching slot in a different cycle, which a design that keys delay or drop on the slot alone would wrongly hit. It also combines drop with delay, so a wrong priority shows up as a late frame or a stray overflow pulse. It runs random-mode frames against an independent LFSR model, so a wrong tap, seed or advance point moves which frames get corrupted.

// File: rtl/tt_fi_pkg.sv
package tt_fi_pkg;
  localparam logic [15:0] LFSR_SEED = 16'hACE1;

  typedef struct packed {
    logic bit_e;
    logic frm_e;
    logic dly;
    logic drop;
    logic ovf;
  } fault_t;

  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/fi_target.sv
module fi_target
  import tt_fi_pkg::*;
#(
  parameter int SLOT_W = 11,
  parameter int CYC_W  = 6,
  parameter int BYTE_W = 8,
  parameter int DLY_W  = 6,
  parameter int REM_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sof_i,
  input  logic [SLOT_W-1:0] slot_id_i,
  input  logic [CYC_W-1:0]  cycle_num_i,
  input  logic [REM_W-1:0]  slot_rem_i,
  input  logic              en_bit_i,
  input  logic              en_frame_i,
  input  logic              en_delay_i,
  input  logic              en_drop_i,
  input  logic              en_rand_i,
  input  logic [SLOT_W-1:0] tgt_slot_i,
  input  logic [CYC_W-1:0]  tgt_cycle_i,
  input  logic [DLY_W-1:0]  dly_ticks_i,
  output fault_t            cur_o,
  output logic [BYTE_W-1:0] idx_o,
  output logic [DLY_W-1:0]  dly_o
);
  logic [15:0]       lfsr_q;
  fault_t            held_q, nf;
  logic [BYTE_W-1:0] idx_q;
  logic [DLY_W-1:0]  dly_q;
  logic              hit_s, hit_c, want_dly, start;

  assign start = valid_i & sof_i;

  always_comb begin
    hit_s    = en_rand_i ? (lfsr_q[2:0] == 3'd0) : (slot_id_i == tgt_slot_i);
    hit_c    = en_rand_i ? hit_s : (hit_s && (cycle_num_i == tgt_cycle_i));
    nf       = '0;
    nf.bit_e = en_bit_i & hit_s;
    nf.frm_e = en_frame_i & hit_s;
    nf.drop  = en_drop_i & hit_c;
    want_dly = en_delay_i & hit_c & (dly_ticks_i != '0) & ~nf.drop;
    if (want_dly) begin
      if (REM_W'(dly_ticks_i) >= slot_rem_i) begin
        nf.ovf  = 1'b1;
        nf.drop = 1'b1;
      end else begin
        nf.dly = 1'b1;
      end
    end
  end

  assign cur_o = start ? nf : held_q;
  assign idx_o = sof_i ? '0 : idx_q;
  assign dly_o = dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q <= LFSR_SEED;
      held_q <= '0;
      idx_q  <= '0;
      dly_q  <= '0;
    end else begin
      if (start) begin
        lfsr_q <= lfsr_step(lfsr_q);
        held_q <= nf;
        if (nf.dly) dly_q <= dly_ticks_i;
      end
      if (valid_i) idx_q <= idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/fi_corrupt.sv
module fi_corrupt #(
  parameter int BYTE_W = 8
) (
  input  logic [7:0]        data_i,
  input  logic [BYTE_W-1:0] idx_i,
  input  logic [BYTE_W-1:0] tgt_byte_i,
  input  logic [2:0]        tgt_bit_i,
  input  logic              bit_e_i,
  input  logic              frm_e_i,
  output logic [7:0]        data_o
);
  logic [7:0] bit_mask;

  always_comb begin
    bit_mask = '0;
    if (bit_e_i && (idx_i == tgt_byte_i)) bit_mask[tgt_bit_i] = 1'b1;
    data_o = data_i ^ bit_mask ^ {7'd0, frm_e_i};
  end
endmodule

// File: rtl/fi_delay_line.sv
module fi_delay_line #(
  parameter int DEPTH = 64,
  parameter int W     = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  wr_i,
  input  logic [AW-1:0] dly_i,
  output logic [W-1:0]  rd_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q;

  // written every tick; tap at age dly_i
  assign rd_o = mem_q[wp_q - dly_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      mem_q[wp_q] <= wr_i;
      wp_q        <= wp_q + 1'b1;
    end
  end
endmodule

// File: rtl/tt_fault_inj.sv
module tt_fault_inj
  import tt_fi_pkg::*;
#(
  parameter int SLOT_W = 11,
  parameter int CYC_W  = 6,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 64,
  parameter int REM_W  = 16,
  localparam int DLY_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_valid_i,
  input  logic              tx_sof_i,
  input  logic [7:0]        tx_data_i,
  input  logic [SLOT_W-1:0] slot_id_i,
  input  logic [CYC_W-1:0]  cycle_num_i,
  input  logic [REM_W-1:0]  slot_rem_i,
  input  logic              en_bit_i,
  input  logic              en_frame_i,
  input  logic              en_delay_i,
  input  logic              en_drop_i,
  input  logic              en_rand_i,
  input  logic [SLOT_W-1:0] tgt_slot_i,
  input  logic [CYC_W-1:0]  tgt_cycle_i,
  input  logic [BYTE_W-1:0] tgt_byte_i,
  input  logic [2:0]        tgt_bit_i,
  input  logic [DLY_W-1:0]  dly_ticks_i,
  output logic [7:0]        bus_data_o,
  output logic              bus_txen_o,
  output logic              dly_ovf_o
);
  fault_t            cur;
  logic [BYTE_W-1:0] idx;
  logic [DLY_W-1:0]  dly;
  logic [7:0]        cdata;
  logic [8:0]        ring_wr, ring_rd;
  logic              direct;
  logic [7:0]        data_q;
  logic              txen_q, ovf_q;

  fi_target #(
    .SLOT_W(SLOT_W), .CYC_W(CYC_W), .BYTE_W(BYTE_W), .DLY_W(DLY_W), .REM_W(REM_W)
  ) u_tgt (
    .clk_i, .rst_ni,
    .valid_i(tx_valid_i), .sof_i(tx_sof_i),
    .slot_id_i, .cycle_num_i, .slot_rem_i,
    .en_bit_i, .en_frame_i, .en_delay_i, .en_drop_i, .en_rand_i,
    .tgt_slot_i, .tgt_cycle_i, .dly_ticks_i,
    .cur_o(cur), .idx_o(idx), .dly_o(dly)
  );

  fi_corrupt #(.BYTE_W(BYTE_W)) u_cor (
    .data_i(tx_data_i), .idx_i(idx), .tgt_byte_i, .tgt_bit_i,
    .bit_e_i(cur.bit_e), .frm_e_i(cur.frm_e), .data_o(cdata)
  );

  assign ring_wr = {tx_valid_i & cur.dly, cdata};

  fi_delay_line #(.DEPTH(DEPTH), .W(9)) u_dly (
    .clk_i, .rst_ni, .wr_i(ring_wr), .dly_i(dly), .rd_o(ring_rd)
  );

  assign direct = tx_valid_i & ~cur.drop & ~cur.dly;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txen_q <= 1'b0;
      data_q <= 8'hFF;
      ovf_q  <= 1'b0;
    end else begin
      ovf_q <= tx_valid_i & tx_sof_i & cur.ovf;
      if (ring_rd[8]) begin
        txen_q <= 1'b1;
        data_q <= ring_rd[7:0];
      end else if (direct) begin
        txen_q <= 1'b1;
        data_q <= cdata;
      end else begin
        txen_q <= 1'b0;
        data_q <= 8'hFF;
      end
    end
  end

  assign bus_data_o = data_q;
  assign bus_txen_o = txen_q;
  assign dly_ovf_o  = ovf_q;
endmodule

// File: rtl/tt_fi_chk.sv
module tt_fi_chk #(
  parameter int SLOT_W = 11,
  parameter int CYC_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_valid_i,
  input logic              tx_sof_i,
  input logic [7:0]        tx_data_i,
  input logic [SLOT_W-1:0] slot_id_i,
  input logic [CYC_W-1:0]  cycle_num_i,
  input logic              en_bit_i,
  input logic              en_frame_i,
  input logic              en_delay_i,
  input logic              en_drop_i,
  input logic              en_rand_i,
  input logic [SLOT_W-1:0] tgt_slot_i,
  input logic [CYC_W-1:0]  tgt_cycle_i,
  input logic [7:0]        bus_data_o,
  input logic              bus_txen_o,
  input logic              dly_ovf_o
);
  // R1
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_txen_o |-> bus_data_o == 8'hFF);

  // R8
  ovf_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dly_ovf_o |-> $past(tx_valid_i && tx_sof_i && en_delay_i));

  // R7
  drop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_sof_i && en_drop_i && !en_rand_i &&
     slot_id_i == tgt_slot_i && cycle_num_i == tgt_cycle_i) |=> !bus_txen_o);

  // R2
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && !en_bit_i && !en_frame_i && !en_delay_i && !en_drop_i)
      |=> (bus_txen_o && bus_data_o == $past(tx_data_i)));
endmodule

bind tt_fault_inj tt_fi_chk #(.SLOT_W(SLOT_W), .CYC_W(CYC_W)) u_chk (
  .clk_i, .rst_ni, .tx_valid_i, .tx_sof_i, .tx_data_i, .slot_id_i, .cycle_num_i,
  .en_bit_i, .en_frame_i, .en_delay_i, .en_drop_i, .en_rand_i,
  .tgt_slot_i, .tgt_cycle_i, .bus_data_o, .bus_txen_o, .dly_ovf_o
);

// File: tb/sim_tt_fault_inj.sv
module sim_tt_fault_inj;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tx_valid = 0, tx_sof = 0;
  logic [7:0]  tx_data = 0;
  logic [10:0] slot_id = 0, tgt_slot = 0;
  logic [5:0]  cycle_num = 0, tgt_cycle = 0, dly_ticks = 0;
  logic [15:0] slot_rem = 16'd1000;
  logic        en_bit = 0, en_frame = 0, en_delay = 0, en_drop = 0, en_rand = 0;
  logic [7:0]  tgt_byte = 0;
  logic [2:0]  tgt_bit = 0;
  logic [7:0]  bus_data;
  logic        bus_txen, dly_ovf;

  int checks = 0, errors = 0, cnt = 0;
  string cur_req = "R1";
  bit [7:0] ed [int];
  bit ovf_at [int];
  logic [15:0] mlfsr = 16'hACE1;
  int rand_hits = 0;

  always #4 clk = ~clk;

  tt_fault_inj u0 (
    .clk_i(clk), .rst_ni(rst_n), .tx_valid_i(tx_valid), .tx_sof_i(tx_sof),
    .tx_data_i(tx_data), .slot_id_i(slot_id), .cycle_num_i(cycle_num),
    .slot_rem_i(slot_rem), .en_bit_i(en_bit), .en_frame_i(en_frame),
    .en_delay_i(en_delay), .en_drop_i(en_drop), .en_rand_i(en_rand),
    .tgt_slot_i(tgt_slot), .tgt_cycle_i(tgt_cycle), .tgt_byte_i(tgt_byte),
    .tgt_bit_i(tgt_bit), .dly_ticks_i(dly_ticks),
    .bus_data_o(bus_data), .bus_txen_o(bus_txen), .dly_ovf_o(dly_ovf)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic compare(int n);
    bit       e_en = ed.exists(n);
    bit [7:0] e_d  = e_en ? ed[n] : 8'hFF;
    bit       e_o  = ovf_at.exists(n);
    checks++;
    if (bus_txen !== e_en || bus_data !== e_d || dly_ovf !== e_o) begin
      errors++;
      $display("FAIL %s t=%0d txen/data/ovf actual %b/%h/%b expected %b/%h/%b",
               cur_req, n, bus_txen, bus_data, dly_ovf, e_en, e_d, e_o);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    cnt++;
    @(negedge clk);
    compare(cnt);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // behavioural model of targeting, corruption and timing
  task automatic send(int slot, int cyc, int rem, int len, bit [7:0] base);
    bit hs, hc, fb, ff, fd, fdr, fo;
    int s = cnt;
    if (en_rand) hs = (mlfsr[2:0] == 0);
    else hs = (slot == int'(tgt_slot));
    hc = en_rand ? hs : (hs && cyc == int'(tgt_cycle));
    fb = en_bit & hs;
    ff = en_frame & hs;
    fdr = en_drop & hc;
    fd = 0; fo = 0;
    if (en_delay && hc && dly_ticks != 0 && !fdr) begin
      if (int'(dly_ticks) >= rem) begin fo = 1; fdr = 1; end
      else fd = 1;
    end
    if (en_rand && hs) rand_hits++;
    mlfsr = {mlfsr[14:0], mlfsr[15] ^ mlfsr[13] ^ mlfsr[12] ^ mlfsr[10]};
    if (fo) ovf_at[s + 1] = 1;
    slot_id = 11'(slot); cycle_num = 6'(cyc); slot_rem = 16'(rem);
    for (int i = 0; i < len; i++) begin
      bit [7:0] d = base + 8'(i * 13);
      bit [7:0] c = d;
      if (fb && i == int'(tgt_byte)) c[tgt_bit] = ~c[tgt_bit];
      if (ff) c[0] = ~c[0];
      if (!fdr) ed[s + i + 1 + (fd ? int'(dly_ticks) : 0)] = c;
      tx_valid = 1; tx_sof = (i == 0); tx_data = d;
      tick();
    end
    tx_valid = 0; tx_sof = 0;
    idle(72);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (bus_txen !== 0 || bus_data !== 8'hFF || dly_ovf !== 0) begin
      errors++;
      $display("FAIL R1 in reset txen/data/ovf actual %b/%h/%b expected 0/ff/0",
               bus_txen, bus_data, dly_ovf);
    end
    rst_n = 1;
    idle(4);

    cur_req = "R2";
    send(3, 1, 200, 6, 8'h10);
    send(7, 2, 200, 1, 8'hFE);

    cur_req = "R3";
    tgt_slot = 5; tgt_byte = 2; tgt_bit = 6; en_bit = 1;
    send(5, 0, 200, 5, 8'h20);
    tgt_byte = 0; tgt_bit = 0;
    send(5, 3, 200, 3, 8'h55);
    cur_req = "R5";
    send(4, 0, 200, 5, 8'h20);
    en_bit = 0;

    cur_req = "R4";
    en_frame = 1;
    send(5, 1, 200, 7, 8'h31);
    cur_req = "R10";
    en_bit = 1; tgt_byte = 3; tgt_bit = 0;
    send(5, 1, 200, 5, 8'h44);
    en_bit = 0; en_frame = 0;

    cur_req = "R6";
    en_delay = 1; tgt_cycle = 9; dly_ticks = 10;
    send(5, 9, 200, 6, 8'h60);
    dly_ticks = 63;
    send(5, 9, 200, 4, 8'h70);
    en_bit = 1; tgt_byte = 1; tgt_bit = 3;
    send(5, 9, 200, 4, 8'h80);
    en_bit = 0;
    cur_req = "R5";
    send(5, 8, 200, 4, 8'h90);
    send(6, 9, 200, 4, 8'h90);

    cur_req = "R8";
    dly_ticks = 20;
    send(5, 9, 20, 5, 8'hA0);
    send(5, 9, 21, 5, 8'hA8);
    send(5, 9, 3, 2, 8'hB0);

    cur_req = "R11";
    dly_ticks = 0;
    send(5, 9, 1, 4, 8'hB8);
    en_delay = 0;

    cur_req = "R7";
    en_drop = 1;
    send(5, 9, 200, 6, 8'hC0);
    send(5, 10, 200, 3, 8'hC8);
    cur_req = "R10";
    en_delay = 1; dly_ticks = 30;
    send(5, 9, 5, 4, 8'hD0);
    en_delay = 0; en_drop = 0;

    cur_req = "R9";
    en_rand = 1; en_frame = 1;
    for (int k = 0; k < 20; k++) send(k + 1, k, 200, 3, 8'(k * 9));
    en_frame = 0; en_drop = 1;
    for (int k = 0; k < 20; k++) send(40 + k, k, 200, 2, 8'(k * 5));
    en_drop = 0; en_delay = 1; dly_ticks = 15;
    for (int k = 0; k < 12; k++) send(k, k, (k % 2 == 0) ? 200 : 10, 3, 8'(k * 3));
    en_delay = 0; en_rand = 0;
    checks++;
    if (rand_hits == 0) begin
      errors++;
      $display("FAIL R9 random targets actual %0d expected >0", rand_hits);
    end

    cur_req = "R1";
    idle(10);
    summary();
    $finish;
  end
endmodule